// File: doc/BRIEF.md
# OTG Session and Host-Negotiation Register Pair

This block holds the two software-visible registers that a USB on-the-go device controller uses to start session requests and host-role negotiations and to report their outcome. Software starts an action by setting a request bit in the control register. The controller core reports each result on single-cycle strobes. The block latches the result as a status bit and raises an interrupt flag for it. The core can also report several other OTG events, each of which sets its own flag.

Interrupt flags are cleared by writing 1 to them. When software clears the negotiation-outcome flag, the block also retires both request bits. Issuing a new negotiation request discards the previous negotiation-success status.

Reads are combinational from the offset and have no side effects. A mode input blocks the peripheral-only fields while the controller acts as host.

Top module: `otg_negotiation_regs`

## Requirements
- R1: After synchronous reset, both registers read 0 and `irq` is 0.
- R2: Offset 0x00 is the control register: negotiation request at bit 9, negotiation success at bit 8, session request at bit 1, session success at bit 0. Offset 0x04 is the flag register: debounce done at bit 19, A-device timeout at bit 18, negotiation detected at bit 17, negotiation outcome at bit 9, session outcome at bit 8, session end at bit 2. Every other bit, and every other offset, reads 0 and ignores writes.
- R3: In peripheral mode, a control write with bit 9 = 1 sets the negotiation request, and one with bit 1 = 1 sets the session request, on the next clock.
- R4: A control write with 0 in a request bit clears that request only while flag bit 9 is set. Otherwise the request keeps its value.
- R5: When a write of 1 to flag bit 9 clears that flag, both request bits read 0 from the next clock on.
- R6: The negotiation-success bit is set by `ev_hng_ok` and cleared by `ev_hng_fail`. It is also cleared by a write that takes the negotiation request from 0 to 1. A same-cycle strobe takes precedence over that write.
- R7: The session-success bit is set by `ev_srq_ok` and cleared by `ev_srq_fail`.
- R8: `ev_srq_ok`/`ev_srq_fail` set flag bit 8. `ev_hng_ok`/`ev_hng_fail` set bit 9. `ev_hng_det` sets bit 17, `ev_adev_tmo` bit 18, `ev_dbnc_done` bit 19, and `ev_sess_end` bit 2.
- R9: Writing 1 to a flag clears it and writing 0 leaves it unchanged. A hardware set in the same cycle as the clear leaves the flag set.
- R10: `irq` is 1 exactly when at least one flag is set.
- R11: When `host_mode` = 1, control writes are ignored and both success bits read 0. The stored values reappear once `host_mode` returns to 0.
- R12: Reading either register changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_mode | input | 1 | 1 = host role, 0 = peripheral role |
| bus_wr | input | 1 | Write strobe for the selected offset |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| ev_srq_ok | input | 1 | Session request succeeded |
| ev_srq_fail | input | 1 | Session request failed |
| ev_hng_ok | input | 1 | Host negotiation succeeded |
| ev_hng_fail | input | 1 | Host negotiation failed |
| ev_hng_det | input | 1 | Host negotiation request detected |
| ev_adev_tmo | input | 1 | A-device wait timeout |
| ev_dbnc_done | input | 1 | Connect debounce finished |
| ev_sess_end | input | 1 | Session end detected |
| irq | output | 1 | OR of all set flags |

## Verification
The hardest state to reach from the ports is the retirement path. It requires a request to be pending, the negotiation outcome to have set flag bit 9, and a write-1 to that flag arriving in a cycle with no new outcome strobe. Directed sequences build this state step by step. They then repeat it with a strobe colliding with the clear, which must keep the flag and the requests. Constrained random traffic adds more cases: it biases write data toward the live bits and draws sparse strobe patterns, so requests, outcomes and clears interleave in many orders. The random traffic also toggles host mode, so the masking and write blocking meet every state.

// File: rtl/otg_neg_pkg.sv
package otg_neg_pkg;

    localparam int REG_W     = 32;
    localparam int NUM_FLAGS = 6;

    localparam int OFS_CTL = 'h00;
    localparam int OFS_IRQ = 'h04;

    // control register bit positions
    localparam int CTL_HNP_REQ = 9;
    localparam int CTL_HNG_OK  = 8;
    localparam int CTL_SRQ     = 1;
    localparam int CTL_SRQ_OK  = 0;

    // flag slots (index into the internal flag vector)
    localparam int FL_SESS_END = 0;
    localparam int FL_SRQ_CHG  = 1;
    localparam int FL_HNG_CHG  = 2;
    localparam int FL_HNG_DET  = 3;
    localparam int FL_ADEV_TMO = 4;
    localparam int FL_DBNC     = 5;

    typedef enum logic [1:0] {
        SEL_CTL,
        SEL_IRQ,
        SEL_NONE
    } reg_sel_e;

    typedef struct packed {
        logic hnp_req;
        logic hng_ok;
        logic srq;
        logic srq_ok;
    } ctl_t;

    // register bit position of each flag slot
    function automatic int flag_pos(input int idx);
        case (idx)
            FL_SESS_END: return 2;
            FL_SRQ_CHG:  return 8;
            FL_HNG_CHG:  return 9;
            FL_HNG_DET:  return 17;
            FL_ADEV_TMO: return 18;
            default:     return 19;
        endcase
    endfunction

    // read image of the control register, success fields masked in host role
    function automatic logic [REG_W-1:0] ctl_image(input ctl_t c, input logic host);
        logic [REG_W-1:0] img;
        img              = '0;
        img[CTL_HNP_REQ] = c.hnp_req;
        img[CTL_HNG_OK]  = c.hng_ok & ~host;
        img[CTL_SRQ]     = c.srq;
        img[CTL_SRQ_OK]  = c.srq_ok & ~host;
        return img;
    endfunction

endpackage

// File: rtl/otg_req_cell.sv
module otg_req_cell (
    input  logic clk,
    input  logic rst,
    input  logic wr_en,
    input  logic wr_bit,
    input  logic chg_pending,
    input  logic hw_clr,
    output logic req_q,
    output logic req_rise
);

    assign req_rise = wr_en & wr_bit & ~req_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= 1'b0;
        end else if (wr_en) begin
            if (wr_bit)
                req_q <= 1'b1;
            else if (chg_pending)
                req_q <= 1'b0;
        end else if (hw_clr) begin
            req_q <= 1'b0;
        end
    end

endmodule

// File: rtl/otg_irq_flags.sv
module otg_irq_flags #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_vec,
    input  logic [N-1:0] w1c_vec,
    output logic [N-1:0] flags_q,
    output logic [N-1:0] cleared_vec
);

    for (genvar i = 0; i < N; i++) begin : g_flag
        assign cleared_vec[i] = flags_q[i] & w1c_vec[i] & ~set_vec[i];

        always_ff @(posedge clk) begin
            if (rst)
                flags_q[i] <= 1'b0;
            else if (set_vec[i])
                flags_q[i] <= 1'b1;
            else if (w1c_vec[i])
                flags_q[i] <= 1'b0;
        end
    end

endmodule

// File: rtl/otg_negotiation_regs.sv
module otg_negotiation_regs
    import otg_neg_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_mode,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              ev_srq_ok,
    input  logic              ev_srq_fail,
    input  logic              ev_hng_ok,
    input  logic              ev_hng_fail,
    input  logic              ev_hng_det,
    input  logic              ev_adev_tmo,
    input  logic              ev_dbnc_done,
    input  logic              ev_sess_end,
    output logic              irq
);

    localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(OFS_CTL);
    localparam logic [ADDR_W-1:0] A_IRQ = ADDR_W'(OFS_IRQ);

    reg_sel_e             sel;
    logic                 wr_ctl, wr_irq, periph_wr;
    logic [NUM_FLAGS-1:0] flag_set, w1c_vec, flags_q, flag_cleared;
    logic                 hw_ack;
    logic                 hnp_req_q, srq_q, hng_ok_q, srq_ok_q;
    logic                 hnp_rise, srq_rise;
    ctl_t                 ctl_view;
    logic [REG_W-1:0]     irq_img;
    logic                 unused_bits;

    // ---------------- decode ----------------
    always_comb begin
        if (bus_addr == A_CTL)
            sel = SEL_CTL;
        else if (bus_addr == A_IRQ)
            sel = SEL_IRQ;
        else
            sel = SEL_NONE;
    end

    assign wr_ctl    = bus_wr & (sel == SEL_CTL);
    assign wr_irq    = bus_wr & (sel == SEL_IRQ);
    assign periph_wr = wr_ctl & ~host_mode;

    // ---------------- interrupt flags ----------------
    always_comb begin
        flag_set              = '0;
        flag_set[FL_SESS_END] = ev_sess_end;
        flag_set[FL_SRQ_CHG]  = ev_srq_ok | ev_srq_fail;
        flag_set[FL_HNG_CHG]  = ev_hng_ok | ev_hng_fail;
        flag_set[FL_HNG_DET]  = ev_hng_det;
        flag_set[FL_ADEV_TMO] = ev_adev_tmo;
        flag_set[FL_DBNC]     = ev_dbnc_done;
    end

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_w1c
        assign w1c_vec[i] = wr_irq & bus_wdata[flag_pos(i)];
    end

    otg_irq_flags #(.N(NUM_FLAGS)) u_flags (
        .clk        (clk),
        .rst        (rst),
        .set_vec    (flag_set),
        .w1c_vec    (w1c_vec),
        .flags_q    (flags_q),
        .cleared_vec(flag_cleared)
    );

    // acknowledging the negotiation outcome retires both requests
    assign hw_ack = flag_cleared[FL_HNG_CHG];

    // ---------------- request bits ----------------
    otg_req_cell u_hnp (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (periph_wr),
        .wr_bit     (bus_wdata[CTL_HNP_REQ]),
        .chg_pending(flags_q[FL_HNG_CHG]),
        .hw_clr     (hw_ack),
        .req_q      (hnp_req_q),
        .req_rise   (hnp_rise)
    );

    otg_req_cell u_srq (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (periph_wr),
        .wr_bit     (bus_wdata[CTL_SRQ]),
        .chg_pending(flags_q[FL_HNG_CHG]),
        .hw_clr     (hw_ack),
        .req_q      (srq_q),
        .req_rise   (srq_rise)
    );

    // ---------------- outcome status ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            hng_ok_q <= 1'b0;
            srq_ok_q <= 1'b0;
        end else begin
            if (ev_hng_ok)
                hng_ok_q <= 1'b1;
            else if (ev_hng_fail || hnp_rise)
                hng_ok_q <= 1'b0;

            if (ev_srq_ok)
                srq_ok_q <= 1'b1;
            else if (ev_srq_fail)
                srq_ok_q <= 1'b0;
        end
    end

    // ---------------- read path ----------------
    assign ctl_view = '{hnp_req: hnp_req_q, hng_ok: hng_ok_q, srq: srq_q, srq_ok: srq_ok_q};

    always_comb begin
        irq_img = '0;
        for (int i = 0; i < NUM_FLAGS; i++)
            irq_img[flag_pos(i)] = flags_q[i];
    end

    always_comb begin
        case (sel)
            SEL_CTL: bus_rdata = ctl_image(ctl_view, host_mode);
            SEL_IRQ: bus_rdata = irq_img;
            default: bus_rdata = '0;
        endcase
    end

    assign irq = |flags_q;

    assign unused_bits = ^{bus_wdata, srq_rise};

endmodule

// File: rtl/otg_negotiation_regs_chk.sv
module otg_negotiation_regs_chk
    import otg_neg_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 host_mode,
    input logic                 bus_wr,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic [REG_W-1:0]     bus_wdata,
    input logic [7:0]           ev_vec,
    input logic [NUM_FLAGS-1:0] flags_q,
    input logic                 hnp_req_q,
    input logic                 srq_q,
    input logic                 hng_ok_q,
    input logic                 irq
);

    // ev_vec: [0] srq ok [1] srq fail [2] hng ok [3] hng fail [4] hng det
    //         [5] adev tmo [6] debounce [7] session end
    logic c_wr_ctl, c_wr_irq;
    assign c_wr_ctl = bus_wr && (bus_addr == ADDR_W'(OFS_CTL));
    assign c_wr_irq = bus_wr && (bus_addr == ADDR_W'(OFS_IRQ));

    p_ack_retires_req_r5: assert property (@(posedge clk) disable iff (rst)
        (c_wr_irq && bus_wdata[9] && flags_q[FL_HNG_CHG] && !ev_vec[2] && !ev_vec[3])
        |=> (!hnp_req_q && !srq_q));

    p_zero_write_ignored_r4: assert property (@(posedge clk) disable iff (rst)
        (c_wr_ctl && !host_mode && !bus_wdata[9] && !flags_q[FL_HNG_CHG])
        |=> $stable(hnp_req_q));

    p_host_write_blocked_r11: assert property (@(posedge clk) disable iff (rst)
        (c_wr_ctl && host_mode) |=> ($stable(hnp_req_q) && $stable(srq_q)));

    p_event_raises_irq_r10: assert property (@(posedge clk) disable iff (rst)
        (|ev_vec) |=> irq);

    p_set_beats_clear_r9: assert property (@(posedge clk) disable iff (rst)
        ev_vec[6] |=> flags_q[FL_DBNC]);

    p_flag_holds_r9: assert property (@(posedge clk) disable iff (rst)
        (flags_q[FL_DBNC] && !(c_wr_irq && bus_wdata[19])) |=> flags_q[FL_DBNC]);

    p_new_req_drops_ok_r6: assert property (@(posedge clk) disable iff (rst)
        (c_wr_ctl && !host_mode && bus_wdata[9] && !hnp_req_q && !ev_vec[2])
        |=> !hng_ok_q);

endmodule

bind otg_negotiation_regs otg_negotiation_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .host_mode(host_mode),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .ev_vec   ({ev_sess_end, ev_dbnc_done, ev_adev_tmo, ev_hng_det,
                ev_hng_fail, ev_hng_ok, ev_srq_fail, ev_srq_ok}),
    .flags_q  (flags_q),
    .hnp_req_q(hnp_req_q),
    .srq_q    (srq_q),
    .hng_ok_q (hng_ok_q),
    .irq      (irq)
);

// File: tb/tb_otg_negotiation_regs.sv
module tb_otg_negotiation_regs;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] FL_MASK = 32'h000E_0304;

    logic        clk = 1'b0;
    logic        rst;
    logic        host_mode;
    logic        bus_wr;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [7:0]  ev_bus;
    logic        irq;

    always #(CLK_PERIOD / 2) clk = ~clk;

    otg_negotiation_regs #(.ADDR_W(8)) dut (
        .clk         (clk),
        .rst         (rst),
        .host_mode   (host_mode),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .ev_srq_ok   (ev_bus[0]),
        .ev_srq_fail (ev_bus[1]),
        .ev_hng_ok   (ev_bus[2]),
        .ev_hng_fail (ev_bus[3]),
        .ev_hng_det  (ev_bus[4]),
        .ev_adev_tmo (ev_bus[5]),
        .ev_dbnc_done(ev_bus[6]),
        .ev_sess_end (ev_bus[7]),
        .irq         (irq)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // bench model of the register state
    logic        m_hnp, m_srq, m_hok, m_sok;
    logic [31:0] m_fl;

    function automatic logic [31:0] exp_ctl();
        logic [31:0] v;
        v    = '0;
        v[9] = m_hnp;
        v[8] = m_hok & ~host_mode;
        v[1] = m_srq;
        v[0] = m_sok & ~host_mode;
        return v;
    endfunction

    function automatic logic [31:0] ev_to_flags(input logic [7:0] ev);
        logic [31:0] s;
        s     = '0;
        s[8]  = ev[0] | ev[1];
        s[9]  = ev[2] | ev[3];
        s[17] = ev[4];
        s[18] = ev[5];
        s[19] = ev[6];
        s[2]  = ev[7];
        return s;
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic check_regs(input string tag);
        bus_wr   = 1'b0;
        bus_addr = 8'h00;
        #1 check({tag, " ctl"}, bus_rdata, exp_ctl());
        bus_addr = 8'h04;
        #1 check({tag, " flags"}, bus_rdata, m_fl);
        check({tag, " irq R10"}, {31'b0, irq}, {31'b0, |m_fl});
        bus_addr = 8'h08;
        #1 check({tag, " unmapped R2"}, bus_rdata, 32'h0);
    endtask

    task automatic step(input logic wr, input logic [7:0] a, input logic [31:0] wd,
                        input logic [7:0] ev, input logic host, input string tag);
        logic [31:0] setv, clrm, n_fl;
        logic        wc, ack, rise, n_hnp, n_srq, n_hok, n_sok;
        @(negedge clk);
        bus_wr    = wr;
        bus_addr  = a;
        bus_wdata = wd;
        ev_bus    = ev;
        host_mode = host;
        setv  = ev_to_flags(ev);
        clrm  = (wr && a == 8'h04) ? (wd & FL_MASK) : 32'h0;
        wc    = wr && a == 8'h00 && !host;
        ack   = m_fl[9] & clrm[9] & ~setv[9];
        n_hnp = wc ? (wd[9] ? 1'b1 : (m_fl[9] ? 1'b0 : m_hnp)) : (ack ? 1'b0 : m_hnp);
        n_srq = wc ? (wd[1] ? 1'b1 : (m_fl[9] ? 1'b0 : m_srq)) : (ack ? 1'b0 : m_srq);
        rise  = wc & wd[9] & ~m_hnp;
        n_hok = ev[2] ? 1'b1 : (ev[3] ? 1'b0 : (rise ? 1'b0 : m_hok));
        n_sok = ev[0] ? 1'b1 : (ev[1] ? 1'b0 : m_sok);
        n_fl  = (m_fl & ~clrm) | setv;
        @(posedge clk);
        #1;
        m_hnp = n_hnp; m_srq = n_srq; m_hok = n_hok; m_sok = n_sok; m_fl = n_fl;
        bus_wr = 1'b0;
        ev_bus = 8'h00;
        check_regs(tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] r0;
        void'($urandom(32'd20240611));
        rst = 1'b1; host_mode = 1'b0; bus_wr = 1'b0; bus_addr = 8'h00;
        bus_wdata = 32'h0; ev_bus = 8'h00;
        m_hnp = 0; m_srq = 0; m_hok = 0; m_sok = 0; m_fl = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check_regs("R1 reset");

        // R3 set requests
        step(1, 8'h00, 32'h0000_0202, 8'h00, 0, "R3 set requests");
        check("R3 hnp bit", {31'b0, exp_ctl()[9]}, 32'd1);
        // R4 clearing write without pending flag is ignored
        step(1, 8'h00, 32'h0, 8'h00, 0, "R4 zero write ignored");
        // R6 R8 negotiation success
        step(0, 8'h00, 32'h0, 8'h04, 0, "R6 R8 hng ok");
        // R4 zero write accepted while flag 9 set
        step(1, 8'h00, 32'h0, 8'h00, 0, "R4 zero write accepted");
        // R6 new request drops success
        step(1, 8'h00, 32'h0000_0200, 8'h00, 0, "R6 new request clears ok");
        check("R6 ok cleared", {31'b0, exp_ctl()[8]}, 32'd0);
        // R5 ack with collision: flag stays, requests stay
        step(1, 8'h04, 32'h0000_0200, 8'h08, 0, "R5 R9 ack collides with set");
        // R5 real ack retires requests
        step(1, 8'h00, 32'h0000_0002, 8'h00, 0, "R3 session request");
        step(1, 8'h04, 32'h0000_0200, 8'h00, 0, "R5 ack retires requests");
        check("R5 requests retired", exp_ctl() & 32'h202, 32'h0);
        // R7 session outcomes
        step(0, 8'h00, 32'h0, 8'h01, 0, "R7 R8 srq ok");
        step(0, 8'h00, 32'h0, 8'h02, 0, "R7 srq fail");
        step(0, 8'h00, 32'h0, 8'h01, 0, "R7 srq ok again");
        // R8 each remaining event
        step(0, 8'h00, 32'h0, 8'h10, 0, "R8 hng detect");
        step(0, 8'h00, 32'h0, 8'h20, 0, "R8 adev timeout");
        step(0, 8'h00, 32'h0, 8'h80, 0, "R8 session end");
        // R9 set wins over clear, zero write no effect
        step(1, 8'h04, 32'h0008_0000, 8'h40, 0, "R9 set wins");
        step(1, 8'h04, 32'h0000_0000, 8'h00, 0, "R9 zero write");
        step(1, 8'h04, 32'hFFF1_FCFB, 8'h00, 0, "R2 R9 reserved bits");
        step(1, 8'h04, 32'hFFFF_FFFF, 8'h00, 0, "R9 R10 clear all");
        // R11 host mode
        step(0, 8'h00, 32'h0, 8'h04, 0, "R11 prime ok");
        step(1, 8'h00, 32'h0000_0202, 8'h00, 1, "R11 host write blocked");
        step(0, 8'h00, 32'h0, 8'h00, 0, "R11 ok bits reappear");
        // R2 unmapped write
        step(1, 8'h0C, 32'hFFFF_FFFF, 8'h00, 0, "R2 unmapped write");
        // R12 repeated reads
        bus_addr = 8'h04;
        #1 r0 = bus_rdata;
        @(posedge clk); #1;
        check("R12 reread flags", bus_rdata, r0);
        check_regs("R12 after reads");

        for (int i = 0; i < 1500; i++) begin
            logic [7:0]  a, ev;
            logic [31:0] wd;
            case ($urandom % 3)
                0: a = 8'h00;
                1: a = 8'h04;
                default: a = 8'h08;
            endcase
            wd = $urandom;
            if ($urandom % 2 == 1) wd = wd & (FL_MASK | 32'h0000_0302);
            if ($urandom % 3 == 0)
                ev = 8'(1 << ($urandom % 8));
            else
                ev = 8'($urandom & $urandom & $urandom);
            step(($urandom % 3) != 0, a, wd, ev, ($urandom % 8) == 0,
                 "random R3 R4 R5 R6 R7 R8 R9 R11");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule